// File: doc/BRIEF.md
# Scanline Timing and Video Fetch Address Generator

This block produces a complete VGA raster from its own counters and needs no CPU timing loop. A free-running chain of pixel and line counters makes active-low horizontal and vertical sync pulses, a vertical-blank flag and a blanked colour output. Alongside the timing it produces a video-memory address. The low byte is a column offset that restarts when horizontal sync is active. The high byte is a row page taken from a line counter that restarts when vertical sync is active. The two low bits of the line counter are dropped, so each stored row is shown on four consecutive scanlines.

The block runs at twice the pixel period rate. Each pixel period has two clock slots. In the first slot the block drives its fetch address onto the shared RAM address port. In the second slot the port carries the CPU's address, and `cpu_grant_o` is high to tell the CPU side that it owns the port. RAM data for the display is taken at the end of the CPU slot, after one cycle of RAM latency. It appears on the colour output for the following pixel period. All eight bits of each pixel byte are colour, because sync never depends on memory contents. Software can poll `vblank_o` to find out when no visible line is being drawn.

Top module: `vga_scan_gen`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `hsync_o` and `vsync_o` are 1, `vblank_o` is 0, `color_o` is 0 and `cpu_grant_o` is 0. That first cycle is the display slot of column 0 on line 0.
- R2: `cpu_grant_o` alternates on every clock: 0 in the display slot and 1 in the CPU slot. The two slots together form one pixel period.
- R3: In every CPU slot, `ram_addr_o` equals `cpu_addr_i`.
- R4: In the display slot of a visible pixel, `ram_addr_o[OFF_W-1:0]` equals that pixel's column, counted from 0 at the first visible pixel of the line. The column counter is cleared while horizontal sync is active.
- R5: In the display slot of a visible pixel, `ram_addr_o[ADDR_W-1:OFF_W]` equals the visible line number shifted right by ROW_SH (2 by default). This gives four scanlines per stored row. The line counter is cleared while vertical sync is active, so the page is 0 again on the first line of every frame.
- R6: A line lasts H_VIS+H_FP+H_SYNC+H_BP pixel periods (160+4+24+12 by default). `hsync_o` is 0 for H_SYNC periods that begin H_FP periods after the last visible pixel.
- R7: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (480+10+2+33 by default). `vsync_o` is 0 for V_SYNC lines that begin V_FP lines after the last visible line.
- R8: `vblank_o` is 1 for exactly the lines whose number is V_VIS or more.
- R9: `color_o` holds the `pix_data_i` byte present at the end of a visible pixel's CPU slot, and keeps it for the next pixel period. For non-visible pixels it is 0. `hsync_o`, `vsync_o` and `vblank_o` follow the same one-period delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel period rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | ADDR_W | CPU address, passed through in the CPU slot |
| pix_data_i | input | PIX_W | RAM read data, one cycle after the address |
| ram_addr_o | output | ADDR_W | Shared RAM address: fetch address or CPU address |
| cpu_grant_o | output | 1 | High when the CPU owns the RAM port this cycle |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| vblank_o | output | 1 | High during vertical blanking lines |
| color_o | output | PIX_W | Pixel colour, zero outside the visible area |

## Verification
The hardest condition to reach from the ports is the wrap from the last back-porch line into line 0 of the next frame. At that point the line counter must already have been cleared by vertical sync, so that the page restarts at 0. With the default timing a frame is over 200,000 clocks. The bench therefore builds the block with a reduced raster of 24 pixel periods by 31 lines. It runs three whole frames, so every sync edge and every frame wrap is crossed several times. A behavioural model compares every output on every clock. That model is built only from integer column, line and slot positions.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  // Decoded raster position for the current pixel period
  typedef struct packed {
    logic h_vis;
    logic h_sync;
    logic line_end;
    logic v_vis;
    logic v_sync;
  } raster_t;

endpackage

// File: rtl/vga_slot_arb.sv
module vga_slot_arb #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] disp_addr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              cpu_grant_o,
  output logic              tick_o
);

  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  // phase 0: display slot, phase 1: CPU slot (last cycle of the pixel period)
  assign cpu_grant_o = phase_q;
  assign tick_o      = phase_q;
  assign ram_addr_o  = phase_q ? cpu_addr_i : disp_addr_i;

endmodule

// File: rtl/vga_raster_ctr.sv
module vga_raster_ctr
  import vga_scan_pkg::*;
#(
  parameter int H_VIS  = 160,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 24,
  parameter int H_BP   = 12,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  output raster_t rs_o
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VEND  = HW'(H_VIS);
  localparam logic [HW-1:0] H_SBEG  = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] H_SEND  = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VEND  = VW'(V_VIS);
  localparam logic [VW-1:0] V_SBEG  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] V_SEND  = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h_cnt_q;
  logic [VW-1:0] v_cnt_q;
  logic          h_last, v_last;

  assign h_last = (h_cnt_q == H_LAST);
  assign v_last = (v_cnt_q == V_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_q <= '0;
    end else if (tick_i) begin
      h_cnt_q <= h_last ? '0 : h_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_cnt_q <= '0;
    end else if (tick_i && h_last) begin
      v_cnt_q <= v_last ? '0 : v_cnt_q + 1'b1;
    end
  end

  always_comb begin
    rs_o.h_vis    = (h_cnt_q < H_VEND);
    rs_o.h_sync   = (h_cnt_q >= H_SBEG) && (h_cnt_q < H_SEND);
    rs_o.line_end = h_last;
    rs_o.v_vis    = (v_cnt_q < V_VEND);
    rs_o.v_sync   = (v_cnt_q >= V_SBEG) && (v_cnt_q < V_SEND);
  end

endmodule

// File: rtl/vga_fetch_addr.sv
module vga_fetch_addr
  import vga_scan_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int PAGE_W = 8,
  parameter int ROW_SH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  raster_t                 rs_i,
  output logic [PAGE_W+OFF_W-1:0] disp_addr_o
);

  localparam int LINE_W = PAGE_W + ROW_SH;

  logic [OFF_W-1:0]  off_q;
  logic [LINE_W-1:0] line_q;

  // Column offset: cleared by horizontal sync, advances over visible pixels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          off_q <= '0;
    else if (tick_i) begin
      if (rs_i.h_sync)    off_q <= '0;
      else if (rs_i.h_vis) off_q <= off_q + 1'b1;
    end
  end

  // Line counter: cleared by vertical sync, advances at the end of visible lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          line_q <= '0;
    else if (tick_i) begin
      if (rs_i.v_sync)    line_q <= '0;
      else if (rs_i.line_end && rs_i.v_vis) line_q <= line_q + 1'b1;
    end
  end

  // Dropping the low line bits repeats each stored row
  assign disp_addr_o = {line_q[LINE_W-1:ROW_SH], off_q};

endmodule

// File: rtl/vga_scan_gen.sv
module vga_scan_gen
  import vga_scan_pkg::*;
#(
  parameter int H_VIS  = 160,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 24,
  parameter int H_BP   = 12,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int OFF_W  = 8,
  parameter int PAGE_W = 8,
  parameter int ROW_SH = 2,
  parameter int PIX_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              cpu_grant_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              vblank_o,
  output logic [PIX_W-1:0]  color_o
);

  logic              tick;
  raster_t           rs;
  logic [ADDR_W-1:0] disp_addr;

  vga_slot_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disp_addr_i (disp_addr),
    .cpu_addr_i  (cpu_addr_i),
    .ram_addr_o  (ram_addr_o),
    .cpu_grant_o (cpu_grant_o),
    .tick_o      (tick)
  );

  vga_raster_ctr #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_raster (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rs_o   (rs)
  );

  vga_fetch_addr #(
    .OFF_W(OFF_W), .PAGE_W(PAGE_W), .ROW_SH(ROW_SH)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .rs_i        (rs),
    .disp_addr_o (disp_addr)
  );

  // Output stage: captured at the end of each pixel period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b1;
      vblank_o <= 1'b0;
      color_o  <= '0;
    end else if (tick) begin
      hsync_o  <= ~rs.h_sync;
      vsync_o  <= ~rs.v_sync;
      vblank_o <= ~rs.v_vis;
      color_o  <= (rs.h_vis && rs.v_vis) ? pix_data_i : '0;
    end
  end

endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk #(
  parameter int H_VIS  = 160,
  parameter int V_VIS  = 480,
  parameter int OFF_W  = 8,
  parameter int PAGE_W = 8,
  parameter int ROW_SH = 2,
  parameter int PIX_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [PAGE_W+OFF_W-1:0] cpu_addr_i,
  input logic [PAGE_W+OFF_W-1:0] ram_addr_o,
  input logic                    cpu_grant_o,
  input logic                    hsync_o,
  input logic                    vsync_o,
  input logic                    vblank_o,
  input logic [PIX_W-1:0]        color_o
);

  localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(H_VIS);
  localparam logic [PAGE_W-1:0] PAGE_MAX = PAGE_W'(V_VIS >> ROW_SH);

  a_r2_cpu_to_disp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_grant_o |=> !cpu_grant_o);

  a_r2_disp_to_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_grant_o |=> cpu_grant_o);

  a_r3_cpu_addr_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_grant_o |-> ram_addr_o == cpu_addr_i);

  a_r4_offset_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_grant_o |-> ram_addr_o[OFF_W-1:0] <= OFF_MAX);

  a_r5_page_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_grant_o |-> ram_addr_o[PAGE_W+OFF_W-1:OFF_W] <= PAGE_MAX);

  a_r6_hsync_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_grant_o |=> $stable(hsync_o));

  a_r7_vsync_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> vblank_o);

  a_r9_dark_in_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> color_o == '0);

  a_r9_dark_in_hsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> color_o == '0);

endmodule

bind vga_scan_gen vga_scan_chk #(
  .H_VIS(H_VIS), .V_VIS(V_VIS), .OFF_W(OFF_W),
  .PAGE_W(PAGE_W), .ROW_SH(ROW_SH), .PIX_W(PIX_W)
) u_scan_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .ram_addr_o  (ram_addr_o),
  .cpu_grant_o (cpu_grant_o),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .vblank_o    (vblank_o),
  .color_o     (color_o)
);

// File: tb/vga_scan_gen_test.sv
module vga_scan_gen_test;

  localparam int HV = 16, HF = 2, HS = 4, HB = 2;
  localparam int VV = 24, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int RUN_CLKS = 3 * HT * VT * 2 + 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  pix_data_i = '0;
  logic [15:0] ram_addr_o;
  logic        cpu_grant_o, hsync_o, vsync_o, vblank_o;
  logic [7:0]  color_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vga_scan_gen #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .pix_data_i(pix_data_i),
    .ram_addr_o(ram_addr_o), .cpu_grant_o(cpu_grant_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .vblank_o(vblank_o), .color_o(color_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      if (n_fail <= 20)
        $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ram_fn(input int a);
    return ((a & 255) * 5 + (a >> 8) * 37 + 11) & 255;
  endfunction

  initial begin
    int mh = 0, mv = 0, mph = 0;
    int ehs = 1, evs = 1, evb = 0, ecol = 0;
    int seed = 7;
    bit vis;
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values while reset is low
    chk("R1 hsync in reset", hsync_o, 1);
    chk("R1 colour in reset", color_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < RUN_CLKS; k++) begin
      if (k == 0) begin
        chk("R1 hsync", hsync_o, 1);
        chk("R1 vsync", vsync_o, 1);
        chk("R1 vblank", vblank_o, 0);
        chk("R1 colour", color_o, 0);
        chk("R1 first slot display", cpu_grant_o, 0);
      end
      chk("R2 slot owner", cpu_grant_o, mph);
      vis = (mh < HV) && (mv < VV);
      if (mph == 0) begin
        if (vis) begin
          chk("R4 column offset", int'(ram_addr_o[7:0]), mh);
          chk("R5 row page", int'(ram_addr_o[15:8]), mv >> 2);
        end
        pix_data_i = 8'(ram_fn(int'(ram_addr_o)));
      end else begin
        chk("R3 cpu address", int'(ram_addr_o), int'(cpu_addr_i));
      end
      chk("R6 hsync", hsync_o, ehs);
      chk("R7 vsync", vsync_o, evs);
      chk("R8 vblank", vblank_o, evb);
      chk("R9 colour", int'(color_o), ecol);
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      cpu_addr_i = 16'(seed >> 9);
      if (mph == 1) begin
        ehs  = (mh >= HV + HF && mh < HV + HF + HS) ? 0 : 1;
        evs  = (mv >= VV + VF && mv < VV + VF + VS) ? 0 : 1;
        evb  = (mv >= VV) ? 1 : 0;
        ecol = vis ? ram_fn(((mv >> 2) << 8) | mh) : 0;
        mh++;
        if (mh == HT) begin
          mh = 0;
          mv = (mv + 1) % VT;
        end
      end
      mph ^= 1;
      @(negedge clk);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (RUN_CLKS + 2000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule